// File: doc/BRIEF.md
# Conversion Queue Sequencer

This block walks a queue of conversion command words held in a small command RAM and drives a multi-channel converter through a request/done handshake. Each command word carries a channel number and a pause mark. For every command the block asks the converter for that channel, waits for the result, and stores it in a result table at the same address as the command. A trigger pulse starts the queue at address 0 from idle, or resumes it from a pause.

The queue stops in one of three ways: the command just converted sits immediately before the boundary pointer where a second queue begins, or a fetched command carries the reserved end code, or the command just converted is in the top RAM location. Two sticky flags, completion and pause, sit behind a small register port. Software clears a flag only by writing 0 to it after it has read the flag as 1. Each flag can raise the interrupt line through its own enable.

In software-controlled mode, a pause mark still raises the pause flag, but the queue runs on without stopping.

Top module: `cq_sequencer`

## Requirements
- R1: After reset, `status_o` is 00 (idle), both flags read 0, `irq_o` is 0, and `conv_req_o` is 0. The status encoding is 00 for idle, 01 for active and 10 for paused. The value 11 never appears.
- R2: A `trig_i` pulse while idle starts the queue at command address 0.
- R3: The command word has the pause mark at bit CHAN_W and the channel in bits CHAN_W-1:0. `conv_req_o` stays high with a steady `conv_chan_o` until `conv_done_i`. In the cycle of `conv_done_i`, `res_we_o` is high, `res_addr_o` is the command's address and `res_data_o` equals `conv_res_i`.
- R4: With `bound_i` nonzero, the queue ends after the command at address `bound_i`-1 has been converted. The completion flag (register bit 0) is then set and the status returns to idle. A `bound_i` of 0 means there is no boundary.
- R5: A fetched command whose channel field is all ones (6'h3F by default) ends the queue with no conversion and sets the completion flag.
- R6: The queue ends after the command in the last RAM location (CMD_DEPTH-1) has been converted, and the completion flag is set.
- R7: When `sw_mode_i` is 0, a command with the pause mark sets the pause flag (register bit 1) once its result has been written. The queue then enters the paused state. The next `trig_i` resumes it at the following address.
- R8: If a command with the pause mark is also the last command of the queue, the queue goes idle rather than paused, and both flags are set.
- R9: When `sw_mode_i` is 1, a pause mark sets the pause flag but the queue continues without entering the paused state.
- R10: A flag clears only on reset, or when a write with that bit at 0 follows a read that saw the flag as 1. A write with no prior read of 1 leaves the flag set. Any write disarms the pending read.
- R11: If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R12: `irq_o` is high exactly when the completion flag is set with `cie_i` high, or the pause flag is set with `pie_i` high. The flags update regardless of the enables.
- R13: `trig_i` has no effect while the queue is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger event pulse: start from idle or resume from pause |
| sw_mode_i | input | 1 | 1: software-controlled mode, pause marks do not stop the queue |
| bound_i | input | ADDR_W | First address of the second queue; 0 means none |
| cmd_addr_o | output | ADDR_W | Command RAM read address |
| cmd_data_i | input | CHAN_W+1 | Command RAM read data, valid in the same cycle as the address |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_chan_o | output | CHAN_W | Channel to convert |
| conv_done_i | input | 1 | Converter reports the result is ready |
| conv_res_i | input | RES_W | Conversion result |
| res_we_o | output | 1 | Result table write enable |
| res_addr_o | output | ADDR_W | Result table address |
| res_data_o | output | RES_W | Result table write data |
| reg_rd_i | input | 1 | Flag register read strobe |
| reg_wr_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 0 completion, bit 1 pause |
| reg_rdata_o | output | 2 | Flag read data: bit 0 completion, bit 1 pause |
| cie_i | input | 1 | Completion interrupt enable |
| pie_i | input | 1 | Pause interrupt enable |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 2 | Queue status (00 idle, 01 active, 10 paused) |

## Verification
The bench builds the block with its default parameters: 6-bit channels, a 64-word command RAM and 10-bit results. The 64-word depth is shallow enough that a full walk to the top RAM location finishes in a few hundred cycles, so the end at the top of the RAM is reached directly alongside the boundary end and the end-code end. The converter model answers a fixed number of cycles after each request. This places the hardware completion set on a known edge, so a software clear can be aimed at that same edge to test set priority.

// File: rtl/cq_pkg.sv
package cq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_ACTIVE = 2'b01,
      ST_PAUSED = 2'b10
   } cq_status_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_FETCH,
      PH_CONV,
      PH_HOLD
   } cq_phase_e;

   localparam int FLAG_DONE  = 0;
   localparam int FLAG_PAUSE = 1;
   localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/cq_flag.sv
module cq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic armed_q;
   logic clr;

   // a clear needs a write of 0 that follows a read which saw 1
   assign clr = wr_i && armed_q && !wbit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)      flag_o <= 1'b1;   // hardware set wins (R11)
         else if (clr)   flag_o <= 1'b0;
         if (wr_i)                  armed_q <= 1'b0;
         else if (rd_i && flag_o)   armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
   import cq_pkg::*;
#(
   parameter int CHAN_W    = 6,
   parameter int CMD_DEPTH = 64,
   parameter int RES_W     = 10,
   parameter int ADDR_W    = $clog2(CMD_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              sw_mode_i,
   input  logic [ADDR_W-1:0] bound_i,
   output logic [ADDR_W-1:0] cmd_addr_o,
   input  logic [CHAN_W:0]   cmd_data_i,
   output logic              conv_req_o,
   output logic [CHAN_W-1:0] conv_chan_o,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_res_i,
   output logic              res_we_o,
   output logic [ADDR_W-1:0] res_addr_o,
   output logic [RES_W-1:0]  res_data_o,
   output logic              set_done_o,
   output logic              set_pause_o,
   output cq_status_e        status_o
);
   localparam logic [CHAN_W-1:0] END_CODE = {CHAN_W{1'b1}};
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(CMD_DEPTH - 1);

   cq_phase_e         phase_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [CHAN_W-1:0] chan_q;
   logic              pause_q;

   logic [CHAN_W-1:0] cmd_chan;
   logic              cmd_pause;
   logic              is_end_code;
   logic              last_cmd;
   logic              conv_finish;
   logic [ADDR_W-1:0] ptr_nxt;

   assign cmd_chan    = cmd_data_i[CHAN_W-1:0];
   assign cmd_pause   = cmd_data_i[CHAN_W];
   assign is_end_code = (cmd_chan == END_CODE);
   assign ptr_nxt     = ptr_q + 1'b1;
   assign last_cmd    = (ptr_q == TOP_ADDR) ||
                        ((bound_i != '0) && (ptr_nxt == bound_i));
   assign conv_finish = (phase_q == PH_CONV) && conv_done_i;

   assign cmd_addr_o  = ptr_q;
   assign conv_req_o  = (phase_q == PH_CONV);
   assign conv_chan_o = chan_q;
   assign res_we_o    = conv_finish;
   assign res_addr_o  = ptr_q;
   assign res_data_o  = conv_res_i;

   assign set_done_o  = ((phase_q == PH_FETCH) && is_end_code) ||
                        (conv_finish && last_cmd);
   assign set_pause_o = conv_finish && pause_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ptr_q   <= '0;
         chan_q  <= '0;
         pause_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (trig_i) begin
               ptr_q   <= '0;
               phase_q <= PH_FETCH;
            end
            PH_FETCH: if (is_end_code) begin
               phase_q <= PH_IDLE;
            end else begin
               chan_q  <= cmd_chan;
               pause_q <= cmd_pause;
               phase_q <= PH_CONV;
            end
            PH_CONV: if (conv_done_i) begin
               if (last_cmd) begin
                  phase_q <= PH_IDLE;
               end else begin
                  ptr_q   <= ptr_nxt;
                  phase_q <= (pause_q && !sw_mode_i) ? PH_HOLD : PH_FETCH;
               end
            end
            PH_HOLD: if (trig_i) phase_q <= PH_FETCH;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_IDLE: status_o = ST_IDLE;
         PH_HOLD: status_o = ST_PAUSED;
         default: status_o = ST_ACTIVE;
      endcase
   end
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
   import cq_pkg::*;
#(
   parameter int CHAN_W    = 6,
   parameter int CMD_DEPTH = 64,
   parameter int RES_W     = 10,
   localparam int ADDR_W   = $clog2(CMD_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              sw_mode_i,
   input  logic [ADDR_W-1:0] bound_i,
   output logic [ADDR_W-1:0] cmd_addr_o,
   input  logic [CHAN_W:0]   cmd_data_i,
   output logic              conv_req_o,
   output logic [CHAN_W-1:0] conv_chan_o,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_res_i,
   output logic              res_we_o,
   output logic [ADDR_W-1:0] res_addr_o,
   output logic [RES_W-1:0]  res_data_o,
   input  logic              reg_rd_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_wdata_i,
   output logic [1:0]        reg_rdata_o,
   input  logic              cie_i,
   input  logic              pie_i,
   output logic              irq_o,
   output logic [1:0]        status_o
);
   if (CHAN_W < 1) begin : g_bad_chan
      $error("cq_sequencer: CHAN_W must be at least 1");
   end
   if (CMD_DEPTH < 2) begin : g_bad_depth
      $error("cq_sequencer: CMD_DEPTH must be at least 2");
   end
   if (RES_W < 1) begin : g_bad_res
      $error("cq_sequencer: RES_W must be at least 1");
   end

   cq_status_e          status;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] flag_en;

   cq_ctrl #(
      .CHAN_W    (CHAN_W),
      .CMD_DEPTH (CMD_DEPTH),
      .RES_W     (RES_W),
      .ADDR_W    (ADDR_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig_i),
      .sw_mode_i   (sw_mode_i),
      .bound_i     (bound_i),
      .cmd_addr_o  (cmd_addr_o),
      .cmd_data_i  (cmd_data_i),
      .conv_req_o  (conv_req_o),
      .conv_chan_o (conv_chan_o),
      .conv_done_i (conv_done_i),
      .conv_res_i  (conv_res_i),
      .res_we_o    (res_we_o),
      .res_addr_o  (res_addr_o),
      .res_data_o  (res_data_o),
      .set_done_o  (flag_set[FLAG_DONE]),
      .set_pause_o (flag_set[FLAG_PAUSE]),
      .status_o    (status)
   );

   assign flag_en[FLAG_DONE]  = cie_i;
   assign flag_en[FLAG_PAUSE] = pie_i;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      cq_flag i_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flag_set[g]),
         .rd_i   (reg_rd_i),
         .wr_i   (reg_wr_i),
         .wbit_i (reg_wdata_i[g]),
         .flag_o (flag_q[g])
      );
   end

   assign reg_rdata_o = flag_q;
   assign irq_o       = |(flag_q & flag_en);
   assign status_o    = status;
endmodule

// File: rtl/cq_sequencer_chk.sv
module cq_sequencer_chk #(
   parameter int CHAN_W    = 6,
   parameter int CMD_DEPTH = 64,
   parameter int RES_W     = 10,
   localparam int ADDR_W   = $clog2(CMD_DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_req_o,
   input logic [CHAN_W-1:0] conv_chan_o,
   input logic              conv_done_i,
   input logic [RES_W-1:0]  conv_res_i,
   input logic              res_we_o,
   input logic [RES_W-1:0]  res_data_o,
   input logic              reg_wr_i,
   input logic [1:0]        reg_wdata_i,
   input logic [1:0]        reg_rdata_o,
   input logic              cie_i,
   input logic              pie_i,
   input logic              irq_o,
   input logic [1:0]        status_o
);
   localparam logic [CHAN_W-1:0] END_CODE = {CHAN_W{1'b1}};

   a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'b11);

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_chan_o));

   a_r3_write_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> conv_req_o && conv_done_i && (res_data_o == conv_res_i));

   a_r5_no_end_code_request: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |-> conv_chan_o != END_CODE);

   a_r7_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == 2'b10 |-> !conv_req_o && !res_we_o);

   a_r10_done_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata_o[0]) |-> $past(reg_wr_i) && !$past(reg_wdata_i[0]));

   a_r10_pause_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata_o[1]) |-> $past(reg_wr_i) && !$past(reg_wdata_i[1]));

   a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (reg_rdata_o[0] && cie_i) || (reg_rdata_o[1] && pie_i));
endmodule

bind cq_sequencer cq_sequencer_chk #(
   .CHAN_W    (CHAN_W),
   .CMD_DEPTH (CMD_DEPTH),
   .RES_W     (RES_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_req_o  (conv_req_o),
   .conv_chan_o (conv_chan_o),
   .conv_done_i (conv_done_i),
   .conv_res_i  (conv_res_i),
   .res_we_o    (res_we_o),
   .res_data_o  (res_data_o),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .cie_i       (cie_i),
   .pie_i       (pie_i),
   .irq_o       (irq_o),
   .status_o    (status_o)
);

// File: tb/test_cq_sequencer.sv
module test_cq_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int CHAN_W     = 6;
   localparam int DEPTH      = 64;
   localparam int RES_W      = 10;
   localparam int AW         = $clog2(DEPTH);
   localparam logic [CHAN_W:0] END_WORD = {1'b0, {CHAN_W{1'b1}}};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig = 1'b0, sw_mode = 1'b0;
   logic [AW-1:0]     bound = '0;
   logic [AW-1:0]     cmd_addr;
   logic [CHAN_W:0]   cmd_data;
   logic              conv_req, conv_done;
   logic [CHAN_W-1:0] conv_chan;
   logic [RES_W-1:0]  conv_res;
   logic              res_we;
   logic [AW-1:0]     res_addr;
   logic [RES_W-1:0]  res_data;
   logic              rd = 1'b0, wr = 1'b0;
   logic [1:0]        wdata = 2'b00;
   logic [1:0]        rdata;
   logic              cie = 1'b0, pie = 1'b0;
   logic              irq;
   logic [1:0]        status;

   logic [CHAN_W:0]   ram [DEPTH];
   logic [1:0]        cnt;
   logic [AW+RES_W-1:0] exp_q [$];
   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cq_sequencer #(.CHAN_W(CHAN_W), .CMD_DEPTH(DEPTH), .RES_W(RES_W)) i_cq_sequencer (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_mode_i(sw_mode), .bound_i(bound),
      .cmd_addr_o(cmd_addr), .cmd_data_i(cmd_data),
      .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
      .conv_res_i(conv_res), .res_we_o(res_we), .res_addr_o(res_addr),
      .res_data_o(res_data), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .cie_i(cie), .pie_i(pie), .irq_o(irq), .status_o(status));

   // command RAM and converter models
   assign cmd_data = ram[cmd_addr];
   assign conv_res = {conv_chan, 4'b0101};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0; conv_done <= 1'b0;
      end else if (conv_req && !conv_done) begin
         if (cnt == 2'd2) begin conv_done <= 1'b1; cnt <= '0; end
         else cnt <= cnt + 1'b1;
      end else begin
         conv_done <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   // scoreboard driver side: expected result-table write
   task automatic expect_res(input int addr, input logic [CHAN_W-1:0] ch);
      exp_q.push_back({AW'(addr), ch, 4'b0101});
   endtask

   // scoreboard monitor side
   always @(negedge clk) begin
      if (rst_n && res_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected result write", int'({res_addr, res_data}), 0);
         end else begin
            logic [AW+RES_W-1:0] e;
            e = exp_q.pop_front();
            check({res_addr, res_data} == e, "R3 result write", int'({res_addr, res_data}), int'(e));
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic pulse_trig();
      trig = 1'b1; tick(); trig = 1'b0;
   endtask
   task automatic reg_read();
      rd = 1'b1; tick(); rd = 1'b0;
   endtask
   task automatic reg_write(input logic [1:0] v);
      wr = 1'b1; wdata = v; tick(); wr = 1'b0;
   endtask
   task automatic wait_status(input logic [1:0] s, input string tag);
      int n = 0;
      while (status != s && n < 1000) begin tick(); n++; end
      check(status == s, tag, status, s);
   endtask
   task automatic drained(input string tag);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask
   task automatic clear_all();
      reg_read(); reg_write(2'b00);
      check(rdata == 2'b00, "R10 clear after read", rdata, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ram[i] = END_WORD;
      repeat (3) tick();
      // R1 reset state
      check(status == 2'b00, "R1 status", status, 0);
      check(rdata == 2'b00, "R1 flags", rdata, 0);
      check(!irq && !conv_req, "R1 irq/req", {irq, conv_req}, 0);
      rst_n = 1'b1; tick();

      // R2 R4 R13: bounded queue of four, retrigger while active ignored
      ram[0] = 7'd5; ram[1] = 7'd9; ram[2] = 7'd12; ram[3] = 7'd3; ram[4] = 7'd20;
      bound = AW'(4);
      for (int i = 0; i < 4; i++) expect_res(i, ram[i][CHAN_W-1:0]);
      pulse_trig();
      check(status == 2'b01, "R1 active code", status, 1);
      tick(); tick(); pulse_trig();   // R13
      wait_status(2'b00, "R4 idle at bound");
      drained("R4 results up to bound");
      check(rdata == 2'b01, "R4 completion only", rdata, 1);
      // R12 polling without enable, then enable
      check(irq == 1'b0, "R12 irq masked", irq, 0);
      cie = 1'b1; tick();
      check(irq == 1'b1, "R12 irq enabled", irq, 1);

      // R10 sticky clear protocol
      reg_write(2'b00);
      check(rdata[0] == 1'b1, "R10 write0 without read", rdata, 1);
      reg_read(); reg_write(2'b01); reg_write(2'b00);
      check(rdata[0] == 1'b1, "R10 write disarms", rdata, 1);
      reg_read(); reg_write(2'b00);
      check(rdata[0] == 1'b0 && irq == 1'b0, "R10 cleared", {rdata, irq}, 0);

      // R5 end code
      bound = '0; ram[0] = 7'd7; ram[1] = END_WORD;
      expect_res(0, 6'd7);
      pulse_trig();
      wait_status(2'b00, "R5 idle on end code");
      drained("R5 one result");
      check(rdata == 2'b01, "R5 completion", rdata, 1);
      clear_all();

      // R7 pause and resume
      cie = 1'b0; pie = 1'b1;
      ram[0] = 7'd1; ram[1] = 7'h42; ram[2] = 7'd3; ram[3] = END_WORD;
      expect_res(0, 6'd1); expect_res(1, 6'd2);
      pulse_trig();
      wait_status(2'b10, "R7 paused");
      drained("R7 results before pause");
      check(rdata == 2'b10, "R7 pause flag only", rdata, 2);
      check(irq == 1'b1, "R12 pause irq", irq, 1);
      expect_res(2, 6'd3);
      pulse_trig();
      wait_status(2'b00, "R7 resumed to end");
      drained("R7 resumed at next address");
      check(rdata == 2'b11, "R7 flags after end", rdata, 3);
      clear_all();

      // R9 software-controlled mode runs through the pause mark
      sw_mode = 1'b1;
      for (int i = 0; i < 3; i++) expect_res(i, ram[i][CHAN_W-1:0]);
      pulse_trig();
      wait_status(2'b00, "R9 no pause stop");
      drained("R9 all results");
      check(rdata == 2'b11, "R9 flags", rdata, 3);
      clear_all();
      sw_mode = 1'b0;

      // R8 pause mark on the last command
      bound = AW'(2); ram[0] = 7'd1; ram[1] = 7'h42;
      expect_res(0, 6'd1); expect_res(1, 6'd2);
      pulse_trig();
      wait_status(2'b00, "R8 idle not paused");
      drained("R8 results");
      check(rdata == 2'b11, "R8 both flags", rdata, 3);
      clear_all();

      // R6 end at the top RAM location
      bound = '0;
      for (int i = 0; i < DEPTH; i++) begin
         ram[i] = {1'b0, CHAN_W'(i % 60)};
         expect_res(i, CHAN_W'(i % 60));
      end
      pulse_trig();
      wait_status(2'b00, "R6 idle at top");
      drained("R6 all locations");
      check(rdata == 2'b01, "R6 completion", rdata, 1);

      // R11 set and clear in the same cycle
      bound = AW'(1); ram[0] = 7'd4;
      expect_res(0, 6'd4);
      reg_read();
      pulse_trig();
      while (!conv_done) @(negedge clk);
      wr = 1'b1; wdata = 2'b00;
      tick(); wr = 1'b0;
      check(rdata[0] == 1'b1, "R11 set wins", rdata, 1);
      drained("R11 result");
      clear_all();

      tick();
      report();
   end
endmodule